// File: doc/BRIEF.md
# Timed Self-Clearing Command Controller

This block sits behind a serial port's 16-bit frame assembler. It turns each completed frame into a byte-addressed register write. It also holds a nine-bit global command register whose bits launch one-shot functions: wake-up, software reset, buffer erase, peak clear, status clear, configuration save, standby entry, factory restore and auto-null. A written command bit stays set while its function runs, for a fixed time that depends on the bit. It then clears itself. The functions themselves live elsewhere and are reached only through per-bit start and done strobes.

A second source of dead time is the capture engine. When it reports a finished capture together with the event length, the block applies a pause whose length grows with the event size. While a command or a pause is running, `busy` is high. The surrounding logic uses `busy` to stop sampling, and the block itself throws away every frame that arrives during that time. Time is counted in units of 0.1 ms, and the parameter `TICK_CYC` sets the number of clock cycles in one unit.

Top module: `timed_cmd_ctrl`

## Requirements
- R1: A frame offered on `frame_valid` is a write when bit 15 is 1, and then carries the byte address in bits [14:8] and the data in bits [7:0]. A write to any address other than 0x4A or 0x4B appears on `wr_valid`/`wr_addr`/`wr_data` for exactly one cycle, one clock after the frame is taken. A frame with bit 15 at 0 has no effect.
- R2: Address 0x4A loads command bits 7..0 from the data byte. Address 0x4B loads command bit 8 from data bit 0, and data bits 7..1 at that address are ignored. `cmd_state` bits 15..9 always read 0.
- R3: A command write with any bit set shows those bits in `cmd_state`, and raises `busy`, one clock after the frame is taken.
- R4: Run lengths in 0.1 ms units are: bit 8 = 2, bit 7 = 320, bit 6 = 3500, bit 3 = 240, bit 1 = 3500. A unit is TICK_CYC cycles. Bits 5, 4, 2 and 0 run for 1 cycle. A single command keeps `busy` high for its run length plus one cycle.
- R5: When several bits are written in one frame, they run one at a time from the highest bit to the lowest. `busy` stays high without a gap until the last bit is done, which is the sum over the bits of (run length + 1) cycles.
- R6: A `cap_done` pulse starts a pause of 20 units when `cap_len` ≤ 64, 40 units when it is ≤ 128, 80 units when it is ≤ 256, 160 units when it is ≤ 512, and 330 units for larger values. `busy` is high for exactly the pause length in cycles.
- R7: A frame that arrives while `busy` is high is discarded: it produces no `wr_valid`, sets no command bit, and does not lengthen `busy`.
- R8: `cmd_start` bit b pulses for one cycle when command b begins, and `cmd_done` bit b pulses for one cycle when command b ends, at which point bit b of `cmd_state` is already 0.
- R9: After reset, `busy`, `cmd_state`, `wr_valid`, `cmd_start` and `cmd_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe: a complete 16-bit frame is present |
| frame_data | input | 16 | Received frame |
| cap_done | input | 1 | Capture-complete pulse |
| cap_len | input | LEN_W | Event length of the finished capture, in samples |
| busy | output | 1 | Command or pause in progress; sampling halted, frames dropped |
| cmd_state | output | 16 | Command register readback (bits still pending or running) |
| cmd_start | output | 9 | Per-bit start strobes |
| cmd_done | output | 9 | Per-bit completion strobes |
| wr_valid | output | 1 | Forwarded register write strobe |
| wr_addr | output | 7 | Forwarded write byte address |
| wr_data | output | 8 | Forwarded write data |

## Verification
The bench measures exact `busy` lengths for single long and zero-time commands, and for a frame that mixes several bits. A wrong run-time table, a count that is off by one, or a gap between queued commands all change the measured cycle count. It records the order of the start strobes, which catches a sequencer that serves low bits first. It checks the 0x4B byte with stray high bits, which catches a design that lets bits above 8 leak into the register. It fires frames in the middle of a command. A design that does not gate on `busy` would then forward a write or queue an extra command bit, and the command bit would show up as a longer `busy` or a non-zero readback. Pause lengths are checked at bucket edges and at a length between buckets, which exposes wrong rounding.

// File: rtl/tcc_pkg.sv
// Shared constants and time tables for the timed command controller.
// Assumes: nine command bits; all time values in 0.1 ms units.
package tcc_pkg;
    localparam int CMD_W      = 9;
    localparam int ADDR_W     = 7;
    localparam int MAX_UNITS  = 3500;
    localparam logic [ADDR_W-1:0] ADDR_CMD_LO = 7'h4A;
    localparam logic [ADDR_W-1:0] ADDR_CMD_HI = 7'h4B;

    // Run time of a command bit in 0.1 ms units; 0 means single-cycle
    function automatic int unsigned cmd_units(input int unsigned idx);
        case (idx)
            8:       return 2;
            7:       return 320;
            6:       return 3500;
            3:       return 240;
            1:       return 3500;
            default: return 0;
        endcase
    endfunction

    // Post-capture pause in 0.1 ms units for a given event length
    function automatic int unsigned pause_units(input int unsigned len);
        if (len <= 64)       return 20;
        else if (len <= 128) return 40;
        else if (len <= 256) return 80;
        else if (len <= 512) return 160;
        else                 return 330;
    endfunction
endpackage

// File: rtl/tcc_frame_decode.sv
// Frame decoder: splits a 16-bit write frame into address and data.
// Command-register bytes become a set request for the sequencer, and all
// other addresses are forwarded as a registered one-cycle write.
// Assumes: frame_valid is a single-cycle strobe; busy drops frames.
module tcc_frame_decode
    import tcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [15:0]       frame_data,
    input  logic              busy,
    output logic              set_valid,
    output logic [CMD_W-1:0]  set_bits,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    logic              take;
    logic [ADDR_W-1:0] f_addr;
    logic [7:0]        f_data;

    // Field split and acceptance condition
    always_comb begin
        f_addr    = frame_data[14:8];
        f_data    = frame_data[7:0];
        take      = frame_valid && frame_data[15] && !busy;
        set_valid = 1'b0;
        set_bits  = '0;
        if (take && f_addr == ADDR_CMD_LO) begin
            set_valid = 1'b1;
            set_bits  = {1'b0, f_data};
        end else if (take && f_addr == ADDR_CMD_HI) begin
            set_valid = 1'b1;
            set_bits  = {f_data[0], 8'h00};
        end
    end

    // Registered forward of non-command writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= take && f_addr != ADDR_CMD_LO && f_addr != ADDR_CMD_HI;
            if (take) begin
                wr_addr <= f_addr;
                wr_data <= f_data;
            end
        end
    end

    p_no_wr_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(!busy));
    p_read_frame_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !frame_data[15]) |=> !wr_valid);
endmodule

// File: rtl/tcc_cmd_seq.sv
// Command sequencer: keeps the pending command bits and runs them one at a
// time, highest bit first. Each bit runs for its own time and then clears.
// Assumes: set requests only arrive while the controller is idle.
module tcc_cmd_seq
    import tcc_pkg::*;
#(
    parameter int TICK_CYC = 10000,
    parameter int CNT_W    = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_valid,
    input  logic [CMD_W-1:0] set_bits,
    output logic [CMD_W-1:0] cmd_state,
    output logic [CMD_W-1:0] cmd_start,
    output logic [CMD_W-1:0] cmd_done,
    output logic             seq_busy
);
    logic [CMD_W-1:0] pending, pending_in, top_mask, run_mask;
    logic [3:0]       top_idx, run_bit;
    logic             run_active;
    logic [CNT_W-1:0] cnt, load_val;

    // Cycles a command bit occupies once started
    function automatic int unsigned cyc_of(input logic [3:0] idx);
        int unsigned u;
        u = cmd_units(32'(idx));
        return (u == 0) ? 1 : u * TICK_CYC;
    endfunction

    // Pick the highest pending bit and its counter load value
    always_comb begin
        pending_in = pending | (set_valid ? set_bits : '0);
        top_idx    = '0;
        for (int i = 0; i < CMD_W; i++)
            if (pending[i]) top_idx = 4'(i);
        top_mask = CMD_W'(1) << top_idx;
        run_mask = run_active ? (CMD_W'(1) << run_bit) : '0;
        load_val = CNT_W'(cyc_of(top_idx) - 1);
    end

    // Start, count down and retire one command at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending    <= '0;
            run_active <= 1'b0;
            run_bit    <= '0;
            cnt        <= '0;
            cmd_start  <= '0;
            cmd_done   <= '0;
        end else begin
            cmd_start <= '0;
            cmd_done  <= '0;
            pending   <= pending_in;
            if (run_active) begin
                if (cnt == '0) begin
                    run_active <= 1'b0;
                    cmd_done   <= run_mask;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (pending != '0) begin
                run_active <= 1'b1;
                run_bit    <= top_idx;
                cnt        <= load_val;
                cmd_start  <= top_mask;
                pending    <= pending_in & ~top_mask;
            end
        end
    end

    assign cmd_state = pending | run_mask;
    assign seq_busy  = run_active || (pending != '0);

    p_start_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_start));
    p_highest_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start != '0) |->
        (({1'b0, $past(pending)} & ~({cmd_start, 1'b0} - 10'd1)) == 10'd0));
    p_start_from_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start != '0) |-> (($past(pending) & cmd_start) == cmd_start));
    p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done != '0) |-> ((cmd_state & cmd_done) == '0));
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_active && cnt != '0) |=> (run_active && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/tcc_pause_timer.sv
// Post-capture pause timer: loads a length-dependent pause on each capture
// completion and holds pause_active until it runs out.
// Assumes: a new cap_done during a pause restarts it with the new length.
module tcc_pause_timer
    import tcc_pkg::*;
#(
    parameter int TICK_CYC = 10000,
    parameter int LEN_W    = 11,
    parameter int CNT_W    = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_done,
    input  logic [LEN_W-1:0] cap_len,
    output logic             pause_active
);
    logic [CNT_W-1:0] pcnt, pload;

    // Pause length in cycles minus one
    always_comb pload = CNT_W'(pause_units(32'(cap_len)) * TICK_CYC - 1);

    // Load on capture completion, count down to release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_active <= 1'b0;
            pcnt         <= '0;
        end else if (cap_done) begin
            pause_active <= 1'b1;
            pcnt         <= pload;
        end else if (pause_active) begin
            if (pcnt == '0) pause_active <= 1'b0;
            else            pcnt <= pcnt - 1'b1;
        end
    end

    p_pause_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_active && pcnt != '0 && !cap_done) |=>
        (pause_active && pcnt == $past(pcnt) - 1'b1));
    p_pause_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> pause_active);
endmodule

// File: rtl/timed_cmd_ctrl.sv
// Top of the timed self-clearing command controller: decoder, command
// sequencer and capture pause timer, with a combined busy flag.
// Assumes: frames come from an external 16-bit shift register; busy is
// used outside to halt sampling.
module timed_cmd_ctrl
    import tcc_pkg::*;
#(
    parameter int TICK_CYC = 10000,
    parameter int LEN_W    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_valid,
    input  logic [15:0]      frame_data,
    input  logic             cap_done,
    input  logic [LEN_W-1:0] cap_len,
    output logic             busy,
    output logic [15:0]      cmd_state,
    output logic [8:0]       cmd_start,
    output logic [8:0]       cmd_done,
    output logic             wr_valid,
    output logic [6:0]       wr_addr,
    output logic [7:0]       wr_data
);
    localparam int CNT_W = $clog2(MAX_UNITS * TICK_CYC + 1);

    logic             set_valid, seq_busy, pause_active;
    logic [CMD_W-1:0] set_bits, state_bits;

    tcc_frame_decode u_dec (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
        .frame_data(frame_data), .busy(busy), .set_valid(set_valid),
        .set_bits(set_bits), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    tcc_cmd_seq #(.TICK_CYC(TICK_CYC), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_bits(set_bits),
        .cmd_state(state_bits), .cmd_start(cmd_start), .cmd_done(cmd_done),
        .seq_busy(seq_busy)
    );

    tcc_pause_timer #(.TICK_CYC(TICK_CYC), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_pause (
        .clk(clk), .rst_n(rst_n), .cap_done(cap_done), .cap_len(cap_len),
        .pause_active(pause_active)
    );

    // Combined hold-off and zero-extended readback
    assign busy      = seq_busy || pause_active;
    assign cmd_state = {7'd0, state_bits};

    p_busy_after_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !busy && frame_data[15] && frame_data[14:8] == ADDR_CMD_LO
         && frame_data[7:0] != 8'h00) |=> busy);
    p_drop_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start == '0 && cmd_done == '0) |=> (cmd_state & ~$past(cmd_state)) == 16'd0);
endmodule

// File: tb/timed_cmd_ctrl_test.sv
module timed_cmd_ctrl_test;
    localparam int TICK = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0;
    logic [15:0] frame_data = '0;
    logic        cap_done = 1'b0;
    logic [10:0] cap_len = '0;
    logic        busy, wr_valid;
    logic [15:0] cmd_state;
    logic [8:0]  cmd_start, cmd_done;
    logic [6:0]  wr_addr;
    logic [7:0]  wr_data;

    int checks = 0, fails = 0;
    int starts[16];
    int n_starts;
    bit saw_wr;

    always #5 clk = ~clk;

    timed_cmd_ctrl #(.TICK_CYC(TICK), .LEN_W(11)) uut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
        .frame_data(frame_data), .cap_done(cap_done), .cap_len(cap_len),
        .busy(busy), .cmd_state(cmd_state), .cmd_start(cmd_start),
        .cmd_done(cmd_done), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    function automatic int run_len(input int b);
        int u;
        case (b)
            8: u = 2; 7: u = 320; 6: u = 3500; 3: u = 240; 1: u = 3500;
            default: u = 0;
        endcase
        return (u == 0) ? 1 : u * TICK;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Present one frame; returns at the first negedge after it is taken
    task automatic send(input logic [15:0] f);
        @(negedge clk);
        frame_valid = 1'b1;
        frame_data  = f;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    // Count busy cycles from the current negedge, logging start strobes
    task automatic measure(output int cnt);
        cnt = 0; n_starts = 0; saw_wr = 0;
        while (busy && cnt < 20000) begin
            cnt++;
            for (int b = 8; b >= 0; b--)
                if (cmd_start[b] && n_starts < 16) begin
                    starts[n_starts] = b; n_starts++;
                end
            if (wr_valid) saw_wr = 1;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check(busy == 0, "R9", "busy", busy, 0);
        check(cmd_state == 0, "R9", "cmd_state", cmd_state, 0);
        check(wr_valid == 0 && cmd_start == 0 && cmd_done == 0, "R9", "strobes",
              {wr_valid, cmd_start, cmd_done}, 0);
    endtask

    task automatic t_forward;
        send(16'hA20A);
        check(wr_valid == 1, "R1", "wr_valid", wr_valid, 1);
        check(wr_addr == 7'h22 && wr_data == 8'h0A, "R1", "addr/data",
              {wr_addr, wr_data}, {7'h22, 8'h0A});
        check(busy == 0, "R1", "busy after plain write", busy, 0);
        @(negedge clk);
        check(wr_valid == 0, "R1", "wr_valid one cycle", wr_valid, 0);
        send(16'h4A04);
        check(wr_valid == 0 && busy == 0 && cmd_state == 0, "R1", "read frame ignored",
              {wr_valid, busy, cmd_state}, 0);
    endtask

    task automatic t_single(input logic [15:0] f, input int b, input string req);
        int cnt;
        send(f);
        check(cmd_state == (16'd1 << b), "R3", "cmd_state after write", cmd_state, 1 << b);
        check(busy == 1, "R3", "busy raised", busy, 1);
        measure(cnt);
        check(cnt == run_len(b) + 1, req, "busy length", cnt, run_len(b) + 1);
        check(n_starts == 1 && starts[0] == b, "R8", "start strobe bit", starts[0], b);
        check(cmd_state == 0, "R8", "bit self-cleared", cmd_state, 0);
    endtask

    task automatic t_hi_byte;
        int cnt;
        send(16'hCBFF);
        check(cmd_state == 16'h0100, "R2", "0x4B stray bits ignored", cmd_state, 16'h0100);
        measure(cnt);
        check(cnt == run_len(8) + 1, "R4", "wake length", cnt, run_len(8) + 1);
    endtask

    task automatic t_multi(input logic [7:0] bits, input string req);
        int cnt, exp, k;
        exp = 0;
        for (int b = 0; b < 8; b++) if (bits[b]) exp += run_len(b) + 1;
        send({8'hCA, bits});
        check(cmd_state == {8'h00, bits}, "R3", "multi cmd_state", cmd_state, bits);
        measure(cnt);
        check(cnt == exp, req, "multi busy length", cnt, exp);
        k = 0;
        for (int b = 7; b >= 0; b--)
            if (bits[b]) begin
                check(k < n_starts && starts[k] == b, "R5", "start order", starts[k], b);
                k++;
            end
        check(n_starts == k, "R5", "start count", n_starts, k);
    endtask

    task automatic t_pause(input int len, input int units);
        int cnt;
        @(negedge clk);
        cap_done = 1'b1; cap_len = 11'(len);
        @(negedge clk);
        cap_done = 1'b0;
        measure(cnt);
        check(cnt == units * TICK, "R6", $sformatf("pause len %0d", len), cnt, units * TICK);
    endtask

    task automatic t_drop;
        int cnt;
        bit wr_seen;
        wr_seen = 0;
        send(16'hCA80);
        cnt = 0;
        while (busy && cnt < 20000) begin
            cnt++;
            if (wr_valid) wr_seen = 1;
            if (cnt == 10) begin frame_valid = 1; frame_data = 16'hA055; end
            else if (cnt == 20) begin frame_valid = 1; frame_data = 16'hCA01; end
            else frame_valid = 0;
            @(negedge clk);
        end
        frame_valid = 0;
        check(wr_seen == 0, "R7", "no forwarded write while busy", wr_seen, 0);
        check(cnt == run_len(7) + 1, "R7", "busy not extended", cnt, run_len(7) + 1);
        repeat (3) @(negedge clk);
        check(busy == 0 && cmd_state == 0, "R7", "dropped command not queued",
              {busy, cmd_state}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_forward();
        t_single(16'hCB01, 8, "R4");
        t_single(16'hCA80, 7, "R4");
        t_single(16'hCA08, 3, "R4");
        t_single(16'hCA01, 0, "R4");
        t_hi_byte();
        t_multi(8'h2D, "R5");
        t_multi(8'h42, "R5");
        t_pause(64, 20);
        t_pause(1, 20);
        t_pause(100, 40);
        t_pause(256, 80);
        t_pause(1024, 330);
        t_drop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule